// File: doc/BRIEF.md
# Converter Result Output Interface

This block holds the most recent 16-bit result of an upstream converter model and hands it to a host over a shared data bus. A conversion-start strobe raises a busy flag for a fixed number of clock cycles. While busy is high, the upstream model supplies its raw word through a valid/data pair. When busy falls, that word becomes the visible result. Between those two points the host can keep reading, and it always sees the previous complete result.

The host picks the transfer style with a mode pin. In parallel mode the whole word appears on the 16 bus lines, and a swap pin exchanges the two bytes so an 8-bit host can fetch both halves from one byte lane. In serial mode one bus line carries the word most significant bit first. The line advances one bit per host serial clock pulse. A coding pin selects straight offset binary or twos complement in both modes. Active-low select and read inputs gate the bus drivers: if either one is high, the pads are released.

Top module: `conv_result_if`

## Requirements
- R1: The bus enable `dbus_en` is 1 only when both `cs_n` and `rd_n` are 0. While it is 0 the pads are high impedance, and `dbus` reads as all zeros.
- R2: With `ser_mode` = 0 and the bus enabled, `dbus` carries the formatted result word. It reacts to pin changes in the same cycle.
- R3: In parallel mode, `swap_bytes` = 0 puts result bits [7:0] on `dbus[7:0]` and bits [15:8] on `dbus[15:8]`. With `swap_bytes` = 1, result bits [7:0] appear on `dbus[15:8]` and bits [15:8] appear on `dbus[7:0]`.
- R4: `twos_sel` = 0 gives the stored word unchanged (offset binary). `twos_sel` = 1 gives the stored word with its bit 15 inverted (twos complement). The coding applies in both modes, and it is applied before any byte swap.
- R5: With `ser_mode` = 1, serial data appears on `dbus[SDO_LANE]` (default lane 0) and every other line is 0. On selection the line shows coded bit 15. A falling edge of `sclk` seen at a `clk` edge moves the line to the next lower bit. `swap_bytes` has no effect in this mode.
- R6: While `cs_n` is 1 the serial position is held at the first bit. Selecting again after a partial shift therefore restarts from bit 15.
- R7: After 16 `sclk` falling edges the serial line stays 0 for any further pulses until `cs_n` goes high.
- R8: A `conv_start` seen while idle raises `busy` from the next cycle for exactly BUSY_CYCLES cycles. A `conv_start` seen while `busy` is high is ignored.
- R9: The result word changes only at the clock edge where `busy` falls. It takes the last `res_data` accepted with `res_valid` before that edge. Reads during a conversion return the previous result.
- R10: After reset, `busy` is 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion-start strobe |
| res_valid | input | 1 | Upstream raw word valid |
| res_data | input | 16 | Upstream raw word |
| ser_mode | input | 1 | 0 parallel, 1 serial |
| swap_bytes | input | 1 | Exchange byte lanes in parallel mode |
| twos_sel | input | 1 | 0 offset binary, 1 twos complement |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| sclk | input | 1 | Host serial clock, sampled by clk |
| busy | output | 1 | Conversion in progress |
| dbus | output | 16 | Data bus value (0 when released) |
| dbus_en | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
Format, swap and gating pins act combinationally, so their results are due at the next sample point after the pins change. `busy` rises one edge after the start strobe. The result lands on the edge where `busy` falls, BUSY_CYCLES edges later. Each serial step takes effect at the first clock edge that sees `sclk` low after it was high. The driver changes inputs just after a rising edge and pushes each expectation at the edge where that count says the output is due. The monitor compares at the following falling edge, so every check lands exactly on the due cycle.

// File: rtl/cri_pkg.sv
package cri_pkg;

    localparam int DEF_WORD_W  = 16;
    localparam int DEF_BUSY    = 8;
    localparam int DEF_SDOLANE = 0;

    typedef enum logic {
        MODE_PARALLEL = 1'b0,
        MODE_SERIAL   = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       swap;
        logic       twos;
    } out_cfg_t;

    function automatic out_cfg_t make_cfg(logic ser, logic swp, logic tw);
        out_cfg_t c;
        c.mode = ser ? MODE_SERIAL : MODE_PARALLEL;
        c.swap = swp;
        c.twos = tw;
        return c;
    endfunction

endpackage

// File: rtl/cri_busy_timer.sv
module cri_busy_timer #(
    parameter int BUSY_CYCLES = cri_pkg::DEF_BUSY
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            if (conv_start) cnt <= CNT_W'(BUSY_CYCLES);
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    // R8
    start_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && conv_start) |=> busy);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_start && !done) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/cri_result_store.sv
module cri_result_store #(
    parameter int W = cri_pkg::DEF_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         load,
    output logic [W-1:0] result
);
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            result <= '0;
        end else begin
            if (in_valid) pend <= in_data;
            if (load)     result <= pend;
        end
    end

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(result));

endmodule

// File: rtl/cri_serial_shift.sv
module cri_serial_shift #(
    parameter int W = cri_pkg::DEF_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         sclk,
    input  logic [W-1:0] word,
    output logic         sdo
);
    localparam int IDX_W = $clog2(W + 1);

    logic             sclk_q;
    logic [IDX_W-1:0] idx;
    logic             fall;
    logic [W-1:0]     shifted;

    assign fall = sclk_q & ~sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            idx    <= '0;
        end else begin
            sclk_q <= sclk;
            if (sel_n)
                idx <= '0;
            else if (fall && idx != IDX_W'(W))
                idx <= idx + IDX_W'(1);
        end
    end

    assign shifted = word << idx;
    assign sdo     = shifted[W-1];

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (idx == '0));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && fall && idx < IDX_W'(W)) |=> (idx == $past(idx) + IDX_W'(1)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !fall) |=> $stable(idx));

    // R7
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == IDX_W'(W)) |-> !sdo);

endmodule

// File: rtl/cri_bus_drive.sv
module cri_bus_drive
    import cri_pkg::*;
#(
    parameter int W        = DEF_WORD_W,
    parameter int SDO_LANE = DEF_SDOLANE
) (
    input  out_cfg_t     cfg,
    input  logic [W-1:0] word,
    input  logic         sdo,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic [W-1:0] coded,
    output logic [W-1:0] bus,
    output logic         bus_en
);
    localparam int HALF = W / 2;

    logic [W-1:0] swapped;
    logic [W-1:0] ser_vec;
    logic [W-1:0] chosen;

    always_comb begin
        coded = word;
        if (cfg.twos) coded[W-1] = ~word[W-1];
    end

    assign swapped = cfg.swap ? {coded[HALF-1:0], coded[W-1:HALF]} : coded;

    for (genvar g = 0; g < W; g++) begin : g_lane
        assign ser_vec[g] = (g == SDO_LANE) ? sdo : 1'b0;
    end

    assign chosen = (cfg.mode == MODE_SERIAL) ? ser_vec : swapped;
    assign bus_en = ~(cs_n | rd_n);
    assign bus    = bus_en ? chosen : '0;

endmodule

// File: rtl/conv_result_if.sv
module conv_result_if
    import cri_pkg::*;
#(
    parameter int DATA_W      = DEF_WORD_W,
    parameter int BUSY_CYCLES = DEF_BUSY,
    parameter int SDO_LANE    = DEF_SDOLANE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              ser_mode,
    input  logic              swap_bytes,
    input  logic              twos_sel,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              sclk,
    output logic              busy,
    output logic [DATA_W-1:0] dbus,
    output logic              dbus_en
);
    out_cfg_t          cfg;
    logic              load;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] coded;
    logic              sdo;

    assign cfg = make_cfg(ser_mode, swap_bytes, twos_sel);

    cri_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .conv_start(conv_start),
        .busy(busy), .done(load)
    );

    cri_result_store #(.W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .in_valid(res_valid), .in_data(res_data),
        .load(load), .result(result)
    );

    cri_serial_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sel_n(cs_n), .sclk(sclk),
        .word(coded), .sdo(sdo)
    );

    cri_bus_drive #(.W(DATA_W), .SDO_LANE(SDO_LANE)) u_drive (
        .cfg(cfg), .word(result), .sdo(sdo), .cs_n(cs_n), .rd_n(rd_n),
        .coded(coded), .bus(dbus), .bus_en(dbus_en)
    );

    // R1
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (!dbus_en && dbus == '0));

    // R5
    ser_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_mode && dbus_en) |-> ((dbus & ~(DATA_W'(1) << SDO_LANE)) == '0));

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(load));

endmodule

// File: tb/test_conv_result_if.sv
module test_conv_result_if;
    localparam int W    = 16;
    localparam int BUSY = 8;
    localparam int LANE = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_start = 1'b0, res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic ser_mode = 1'b0, swap_bytes = 1'b0, twos_sel = 1'b0;
    logic cs_n = 1'b0, rd_n = 1'b0, sclk = 1'b0;
    logic busy, dbus_en;
    logic [W-1:0] dbus;

    always #10 clk = ~clk;

    conv_result_if #(.DATA_W(W), .BUSY_CYCLES(BUSY), .SDO_LANE(LANE)) i_conv_result_if (
        .clk(clk), .rst(rst), .conv_start(conv_start), .res_valid(res_valid),
        .res_data(res_data), .ser_mode(ser_mode), .swap_bytes(swap_bytes),
        .twos_sel(twos_sel), .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk),
        .busy(busy), .dbus(dbus), .dbus_en(dbus_en)
    );

    typedef struct {
        string       req;
        int          kind;
        logic [16:0] exp;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;

    always @(negedge clk) begin
        item_t       it;
        logic [16:0] act;
        while (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            act = (it.kind == 0) ? {dbus_en, dbus} : {16'b0, busy};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_bus(string req, logic en, logic [W-1:0] v);
        sb_q.push_back('{req, 0, {en, v}});
    endtask

    task automatic expect_busy(string req, logic b);
        sb_q.push_back('{req, 1, {16'b0, b}});
    endtask

    function automatic logic [W-1:0] fmt(logic [W-1:0] v, logic tw, logic sw);
        logic [W-1:0] c;
        c = tw ? (v ^ 16'h8000) : v;
        return sw ? {c[7:0], c[15:8]} : c;
    endfunction

    task automatic convert(logic [W-1:0] old_v, logic [W-1:0] new_v);
        conv_start = 1'b1;
        step();
        conv_start = 1'b0;
        expect_busy("R8 rise", 1'b1);
        settle();
        for (int k = 1; k < BUSY; k++) begin
            if (k == 1) begin res_valid = 1'b1; res_data = new_v; end
            if (k == 3) conv_start = 1'b1;
            step();
            conv_start = 1'b0;
            res_valid  = 1'b0;
            expect_busy("R8 held", 1'b1);
            expect_bus("R9 read during convert", 1'b1, fmt(old_v, twos_sel, swap_bytes));
            settle();
        end
        step();
        expect_busy("R8 fall", 1'b0);
        expect_bus("R2 new result", 1'b1, fmt(new_v, twos_sel, swap_bytes));
        settle();
        step();
        expect_busy("R8 restart ignored", 1'b0);
        settle();
    endtask

    task automatic serial_pulses(string req, logic [W-1:0] w, int first, int n);
        for (int i = first; i < first + n; i++) begin
            sclk = 1'b1;
            step();
            expect_bus(req, 1'b1, (i < W) ? (W'(w[W-1-i]) << LANE) : '0);
            settle();
            sclk = 1'b0;
            step();
            settle();
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        // R10 reset state
        expect_busy("R10 busy", 1'b0);
        expect_bus("R10 result", 1'b1, '0);
        settle();

        convert(16'h0000, 16'h1234);
        convert(16'h1234, 16'h80F1);

        // R3 / R4 format combinations on 0x80F1
        for (int m = 0; m < 4; m++) begin
            twos_sel   = m[0];
            swap_bytes = m[1];
            step();
            expect_bus(m[1] ? "R3 swap" : "R4 coding", 1'b1, fmt(16'h80F1, m[0], m[1]));
            settle();
        end
        twos_sel = 1'b0; swap_bytes = 1'b0;

        // R1 gating
        cs_n = 1'b1; step(); expect_bus("R1 cs high", 1'b0, '0); settle();
        cs_n = 1'b0; rd_n = 1'b1; step(); expect_bus("R1 rd high", 1'b0, '0); settle();
        rd_n = 1'b0;

        // R5 serial full read, offset binary; swap ignored
        ser_mode = 1'b1; swap_bytes = 1'b1; cs_n = 1'b1;
        step(); settle();
        cs_n = 1'b0;
        step();
        expect_bus("R5 first bit", 1'b1, W'(1'b1) << LANE);
        settle();
        serial_pulses("R5 shift", 16'h80F1, 0, 16);
        // R7 further pulses give zero
        serial_pulses("R7 tail", 16'h80F1, 16, 3);

        // R6 restart after partial shift, twos complement
        cs_n = 1'b1; twos_sel = 1'b1;
        step(); expect_bus("R6 released", 1'b0, '0); settle();
        cs_n = 1'b0;
        serial_pulses("R6 partial", 16'h00F1, 0, 5);
        cs_n = 1'b1; step(); settle();
        cs_n = 1'b0;
        serial_pulses("R6 restart", 16'h00F1, 0, 16);

        settle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule